// File: doc/BRIEF.md
# Cascaded Programmable Clock-Enable Divider Bank

This block derives four divided clock-enable streams from one root clock. Three of the stages form a cascade. The core stage divides the root clock. The high-speed bus stage counts only core enables. The peripheral bus stage counts only high-speed bus enables. A fourth stage, the bridge stage, divides the root clock on its own, in parallel with the core stage. Each enable output is a single root-clock-cycle pulse. Downstream logic uses it as a qualifier, so no derived clock net is needed.

Software programs the four ratio fields through a small register port with two addresses. Address 0 is the read/write control word and address 1 is the read-only status word. A stage never changes its ratio in the middle of an output period. A new value is taken at the next period boundary. The status bit for that stage stays set until the stage has produced its first pulse under the new ratio. Software polls this bit before it relies on the new rate. Keeping output rates within any frequency limits is left to software.

Top module: `cdiv_bank`

## Requirements
- R1: After reset, the control word and the status word both read 0, and every enable output is asserted in every cycle (divide by 1).
- R2: The core enable asserts once every (C+1) root cycles, where C is control bits [2:0].
- R3: The bridge enable asserts once every (B+1) root cycles, where B is control bits [6:4], whatever the core ratio is.
- R4: The high-speed bus enable asserts once every (H+1) core enables, where H is control bits [10:8], and it is never asserted in a cycle without a core enable.
- R5: The peripheral bus enable asserts once every (P+1) high-speed bus enables, where P is control bits [14:12], and it is never asserted in a cycle without a high-speed bus enable.
- R6: Control bits outside [2:0], [6:4], [10:8] and [14:12] ignore writes and read as 0. Status bits other than 0, 4, 8 and 12 read as 0.
- R7: A control write that changes a ratio field sets the status bit of that stage in the next cycle. Status bit 0 is core, 4 is bridge, 8 is high-speed bus and 12 is peripheral bus. A write that leaves a field unchanged does not set that field's status bit.
- R8: A new ratio takes effect only at the end of the stage's current output period. The period in progress completes with the old ratio.
- R9: A status bit stays set until the stage's first enable pulse under the new ratio, and it clears in the cycle after that pulse. From ratio 0, the core status bit reads set for N+2 cycles after a write of ratio N.
- R10: The status word is read-only. A write to address 1 changes neither the control word nor the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Root clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the selected register (combinational) |
| core_en_o | output | 1 | Core clock enable |
| brg_en_o | output | 1 | Bridge clock enable |
| hbus_en_o | output | 1 | High-speed bus clock enable |
| pbus_en_o | output | 1 | Peripheral bus clock enable |

## Verification
The properties assume that the register port is driven only by synchronous, single-cycle write strobes. They also assume that addr_i is stable while rdata_o is compared. The nesting properties and the core gap bound assume that no stage ever sees a ratio above the field's maximum. The stimulus drives every input one nanosecond after the rising edge. It holds each write strobe for exactly one cycle and waits for the status word to reach zero before it measures any period. A boundary write is issued only in a cycle where the core enable is already high.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int NUM_DIV = 4;
  localparam int STRIDE  = 4;

  // stage index = field slot; slot lsb = index*STRIDE
  localparam int DIV_CORE = 0;
  localparam int DIV_BRG  = 1;
  localparam int DIV_HBUS = 2;
  localparam int DIV_PBUS = 3;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  function automatic logic [31:0] ctrl_mask(input int rw);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_DIV; i++)
      for (int b = 0; b < rw; b++) m[i*STRIDE+b] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] stat_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_DIV; i++) m[i*STRIDE] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int RATIO_W = 3,
  parameter int DATA_W  = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic                             addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_DIV-1:0]               busy_i,
  output logic [NUM_DIV-1:0][RATIO_W-1:0]  ratio_o,
  output logic [NUM_DIV-1:0]               req_o,
  output logic [DATA_W-1:0]                rdata_o
);
  logic [NUM_DIV-1:0][RATIO_W-1:0] ratio_q;
  logic [NUM_DIV-1:0][RATIO_W-1:0] fld;
  logic [DATA_W-1:0]               ctrl_img, stat_img;
  logic                            wr_ctrl;
  logic                            unused_wdata;

  assign wr_ctrl      = we_i && (addr_i == ADDR_CTRL);
  assign unused_wdata = ^wdata_i;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_fld
    assign fld[g]   = wdata_i[g*STRIDE +: RATIO_W];
    assign req_o[g] = wr_ctrl && (fld[g] != ratio_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ratio_q <= '0;
    else if (wr_ctrl) ratio_q <= fld;
  end

  always_comb begin
    ctrl_img = '0;
    stat_img = '0;
    for (int i = 0; i < NUM_DIV; i++) begin
      ctrl_img[i*STRIDE +: RATIO_W] = ratio_q[i];
      stat_img[i*STRIDE]            = busy_i[i];
    end
  end

  assign rdata_o = (addr_i == ADDR_STAT) ? stat_img : ctrl_img;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage #(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               req_i,
  output logic               en_o,
  output logic               busy_o
);
  logic [RATIO_W-1:0] cnt_q, act_q;
  logic               pend_q, armed_q, wrap;

  assign wrap   = (cnt_q == act_q);
  assign en_o   = tick_i && wrap;
  assign busy_o = pend_q || armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_q   <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      // ratio swap only at period end
      if (en_o && pend_q) act_q <= ratio_i;
      if (req_i)     pend_q <= 1'b1;
      else if (en_o) pend_q <= 1'b0;
      // armed: first period under new ratio in progress
      if (en_o) armed_q <= pend_q;
    end
  end
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
#(
  parameter int RATIO_W = 3,   // must stay below STRIDE
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              core_en_o,
  output logic              brg_en_o,
  output logic              hbus_en_o,
  output logic              pbus_en_o
);
  logic [NUM_DIV-1:0][RATIO_W-1:0] ratio;
  logic [NUM_DIV-1:0]              req;
  logic [NUM_DIV-1:0]              busy;
  logic core_en, brg_en, hbus_en, pbus_en;
  logic core_busy, brg_busy, hbus_busy, pbus_busy;

  assign busy = {pbus_busy, hbus_busy, brg_busy, core_busy};

  cdiv_regs #(.RATIO_W(RATIO_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .busy_i (busy),
    .ratio_o(ratio),
    .req_o  (req),
    .rdata_o
  );

  cdiv_stage #(.RATIO_W(RATIO_W)) u_core (
    .clk_i, .rst_ni, .tick_i(1'b1),
    .ratio_i(ratio[DIV_CORE]), .req_i(req[DIV_CORE]),
    .en_o(core_en), .busy_o(core_busy)
  );

  cdiv_stage #(.RATIO_W(RATIO_W)) u_brg (
    .clk_i, .rst_ni, .tick_i(1'b1),
    .ratio_i(ratio[DIV_BRG]), .req_i(req[DIV_BRG]),
    .en_o(brg_en), .busy_o(brg_busy)
  );

  cdiv_stage #(.RATIO_W(RATIO_W)) u_hbus (
    .clk_i, .rst_ni, .tick_i(core_en),
    .ratio_i(ratio[DIV_HBUS]), .req_i(req[DIV_HBUS]),
    .en_o(hbus_en), .busy_o(hbus_busy)
  );

  cdiv_stage #(.RATIO_W(RATIO_W)) u_pbus (
    .clk_i, .rst_ni, .tick_i(hbus_en),
    .ratio_i(ratio[DIV_PBUS]), .req_i(req[DIV_PBUS]),
    .en_o(pbus_en), .busy_o(pbus_busy)
  );

  assign core_en_o = core_en;
  assign brg_en_o  = brg_en;
  assign hbus_en_o = hbus_en;
  assign pbus_en_o = pbus_en;
endmodule

// File: rtl/cdiv_bank_chk.sv
module cdiv_bank_chk
  import cdiv_pkg::*;
#(
  parameter int RATIO_W = 3,
  parameter int DATA_W  = 32
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            we_i,
  input logic                            addr_i,
  input logic [DATA_W-1:0]               wdata_i,
  input logic [DATA_W-1:0]               rdata_i,
  input logic [NUM_DIV-1:0][RATIO_W-1:0] ratio_i,
  input logic [NUM_DIV-1:0]              busy_i,
  input logic [NUM_DIV-1:0]              en_i
);
  localparam logic [31:0] CMASK = ctrl_mask(RATIO_W);
  localparam logic [31:0] SMASK = stat_mask();
  localparam int          GAP_MAX = (1 << RATIO_W) - 1;

  logic [RATIO_W:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= '0;
    else if (en_i[DIV_CORE])  gap_q <= '0;
    else if (gap_q <= GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  a_r2_core_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_MAX);

  a_r4_hbus_in_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i[DIV_HBUS] |-> en_i[DIV_CORE]);

  a_r5_pbus_in_hbus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i[DIV_PBUS] |-> en_i[DIV_HBUS]);

  a_r6_ctrl_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTRL) |-> ((rdata_i[31:0] & ~CMASK) == '0));

  a_r6_stat_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> ((rdata_i[31:0] & ~SMASK) == '0));

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    a_r7_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_CTRL && wdata_i[i*STRIDE +: RATIO_W] != ratio_i[i])
      |=> busy_i[i]);

    // R8/R9: busy may only drop right after an output pulse
    a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i[i] && !en_i[i]) |=> busy_i[i]);
  end
endmodule

bind cdiv_bank cdiv_bank_chk #(.RATIO_W(RATIO_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_i (rdata_o),
  .ratio_i (ratio),
  .busy_i  (busy),
  .en_i    ({pbus_en_o, hbus_en_o, brg_en_o, core_en_o})
);

// File: tb/cdiv_bank_tb.sv
`timescale 1ns/1ps
module cdiv_bank_tb;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic addr = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic core_en, brg_en, hbus_en, pbus_en;

  always #2.5 clk = ~clk;  // 200 MHz

  cdiv_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .core_en_o(core_en), .brg_en_o(brg_en),
    .hbus_en_o(hbus_en), .pbus_en_o(pbus_en)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
    end
  endtask

  // scoreboard
  typedef struct { int exp; string req; } item_t;
  item_t exp_q[$];
  int mon_sel = 0;
  int last_t  = -1;
  int cyc     = 0;

  always @(negedge clk) begin
    logic hit;
    item_t it;
    cyc++;
    case (mon_sel)
      0: hit = core_en;
      1: hit = brg_en;
      2: hit = hbus_en;
      default: hit = pbus_en;
    endcase
    if (rst_n && hit) begin
      if (last_t >= 0 && exp_q.size() > 0) begin
        it = exp_q.pop_front();
        check(it.req, cyc - last_t, it.exp);
      end
      last_t = cyc;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [DATA_W-1:0] d);
    step();
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [DATA_W-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [DATA_W-1:0] s;
    int k;
    for (k = 0; k < 5000; k++) begin
      rd(1'b1, s);
      if (s == '0) break;
      step();
    end
    if (k == 5000) check({req, " idle timeout"}, 1, 0);
  endtask

  task automatic drain(input string req);
    int k;
    for (k = 0; k < 20000; k++) begin
      if (exp_q.size() == 0) break;
      step();
    end
    if (k == 20000) begin
      check({req, " scoreboard drain"}, exp_q.size(), 0);
      exp_q.delete();
    end
  endtask

  task automatic measure(input int sel, input int per, input int n, input string req);
    step();
    mon_sel = sel;
    last_t  = -1;
    for (int i = 0; i < n; i++) exp_q.push_back('{per, req});
    drain(req);
  endtask

  initial begin
    #500us;
    n_err++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    int cnt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    rd(1'b0, v); check("R1 ctrl reset", v, 0);
    rd(1'b1, v); check("R1 stat reset", v, 0);
    @(negedge clk);
    check("R1 all enables high", {core_en, brg_en, hbus_en, pbus_en}, 4'hf);
    measure(3, 1, 3, "R1 pbus divide by 1");

    // R7/R9 busy timing: core 0 -> 3
    wr(1'b0, 32'h3);
    rd(1'b1, v); check("R7 core busy after write", v, 32'h1);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      rd(1'b1, v);
      if (v[0]) cnt++; else break;
      step();
    end
    check("R9 core busy length", cnt, 5);

    // R8 boundary: write ratio 1 in the cycle of a core pulse
    step();
    mon_sel = 0; last_t = -1;
    exp_q.push_back('{4, "R8 period finishes with old ratio"});
    exp_q.push_back('{2, "R8 new ratio applied"});
    exp_q.push_back('{2, "R8 new ratio steady"});
    for (int k = 0; k < 40; k++) begin
      if (core_en) break;
      step();
    end
    we = 1'b1; addr = 1'b0; wdata = 32'h1;
    step();
    we = 1'b0;
    drain("R8");
    wait_idle("R8");

    // R6 reserved bits, R7 multi-field busy
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b1, v); check("R7 all busy", v, 32'h1111);
    rd(1'b0, v); check("R6 reserved masked", v, 32'h7777);
    wait_idle("R6");
    measure(0, 8, 2, "R2 core /8");
    measure(1, 8, 2, "R3 brg /8");
    measure(2, 64, 2, "R4 hbus /64");
    measure(3, 512, 2, "R5 pbus /512");

    // mixed ratios
    wr(1'b0, 32'h0000_1221);
    rd(1'b1, v); check("R7 mixed busy", v, 32'h1111);
    wait_idle("mixed");
    measure(0, 2, 3, "R2 core /2");
    measure(1, 3, 3, "R3 brg /3");
    measure(2, 6, 3, "R4 hbus /6");
    measure(3, 12, 3, "R5 pbus /12");

    // R7 unchanged write
    wr(1'b0, 32'h0000_1221);
    rd(1'b1, v); check("R7 same value no busy", v, 0);

    // R10 status read-only
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b0, v); check("R10 ctrl untouched", v, 32'h1221);
    rd(1'b1, v); check("R10 stat untouched", v, 0);

    // only core changes
    wr(1'b0, 32'h0000_1225);
    rd(1'b1, v); check("R7 core-only busy", v, 32'h1);
    wait_idle("core-only");
    measure(2, 18, 2, "R4 hbus follows core");
    measure(1, 3, 2, "R3 brg independent");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule